// File: doc/BRIEF.md
# Dual Four-Mode Addressable Latch

This block holds two independent channels of addressable storage, each driving four output bits. Both channels share a 2-bit bit-select address and two active-low control inputs. Each channel has its own serial data input. The two controls pick one of four operating modes:

- wipe every output to zero;
- steer each channel's data bit to the addressed output and force the other outputs low;
- overwrite only the addressed bit while the rest keep their values;
- freeze everything.

A host loads a parallel word by stepping the address through the bit positions while presenting one data bit per channel, then parks the block in the freeze mode. Any single bit can later be rewritten at random.

The block is built as clocked logic: controls, address and data are sampled on every rising clock edge, and the outputs come straight from the storage registers. Because nothing is level-sensitive, an address that changes in the middle of a write cannot select a wrong bit for a moment.

Top module: `dual_addr_latch`

## Requirements
- R1: While `rst` is high at a rising edge, all eight outputs are 0 after that edge.
- R2: Clear mode (`en_n`=1, `clr_n`=0) drives all eight outputs to 0 after the edge.
- R3: Demultiplex mode (`en_n`=0, `clr_n`=0) sets, in each channel, output bit `addr` equal to that channel's data bit. All other bits of that channel become 0.
- R4: Write mode (`en_n`=0, `clr_n`=1) sets output bit `addr` of each channel to its data bit and leaves the other three bits of that channel unchanged.
- R5: Memory mode (`en_n`=1, `clr_n`=1) leaves all outputs unchanged, whatever `addr` and `din` do.
- R6: Channel A uses `din[0]` and drives `q[3:0]`. Channel B uses `din[1]` and drives `q[7:4]`. Bit index within a channel equals the address value, and both channels use the same address.
- R7: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge. Between edges they do not follow the inputs.
- R8: The pattern shown after a demultiplex cycle is the stored state, so a following memory-mode cycle holds exactly that pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Shared bit-select address |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low conditional clear |
| din | input | 2 | Data bit per channel (bit 0 = A, bit 1 = B) |
| q | output | 8 | Stored bits, channel A in [3:0], channel B in [7:4] |

## Verification
The outputs are the storage registers themselves, so any wrong stored bit shows up on `q` one edge after the cycle that corrupted it. That error then persists through every later memory-mode cycle until a write, clear or reset touches that bit. A reference model is compared on every cycle. Long memory-mode stretches with toggling address and data expose leaks in the hold path. Demultiplex cycles that follow a loaded pattern expose outputs that are held when they should be zeroed.

// File: rtl/dal_pkg.sv
package dal_pkg;
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_DEMUX = 2'd1,
        MODE_WRITE = 2'd2,
        MODE_HOLD  = 2'd3
    } mode_e;
endpackage

// File: rtl/dal_mode_decode.sv
module dal_mode_decode
    import dal_pkg::*;
(
    input  logic  en_n,
    input  logic  clr_n,
    output mode_e mode
);
    always_comb begin
        case ({en_n, clr_n})
            2'b10:   mode = MODE_CLEAR;
            2'b00:   mode = MODE_DEMUX;
            2'b01:   mode = MODE_WRITE;
            default: mode = MODE_HOLD;
        endcase
    end
endmodule

// File: rtl/dal_channel.sv
module dal_channel
    import dal_pkg::*;
#(
    parameter int ADDR_W = 2,
    localparam int BITS  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [BITS-1:0]   q_o
);
    typedef struct packed {
        logic [BITS-1:0] bits;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [BITS-1:0] pick;

    always_comb begin
        st_d       = st_q;
        pick       = '0;
        pick[addr] = 1'b1;
        case (mode)
            MODE_CLEAR: st_d.bits = '0;
            MODE_DEMUX: st_d.bits = din ? pick : '0;
            MODE_WRITE: st_d.bits[addr] = din;
            default:    st_d.bits = st_q.bits;
        endcase
        if (rst) st_d.bits = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_o = st_q.bits;

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (q_o == '0));

    a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CLEAR) |=> (q_o == '0));

    a_r3_demux_one_hot: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DEMUX) |=> ($countones(q_o) <= 1 && q_o[$past(addr)] == $past(din)));

    a_r4_write_others_hold: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WRITE) |=>
            (((q_o ^ $past(q_o)) & ~(BITS'(1) << $past(addr))) == '0));

    a_r4_write_bit: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WRITE) |=> (q_o[$past(addr)] == $past(din)));

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD) |=> $stable(q_o));
endmodule

// File: rtl/dual_addr_latch.sv
module dual_addr_latch
    import dal_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 2,
    localparam int BITS  = 1 << ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   en_n,
    input  logic                   clr_n,
    input  logic [NUM_CH-1:0]      din,
    output logic [NUM_CH*BITS-1:0] q
);
    mode_e mode;

    dal_mode_decode u_decode (
        .en_n  (en_n),
        .clr_n (clr_n),
        .mode  (mode)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dal_channel #(.ADDR_W(ADDR_W)) u_chan (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .addr (addr),
            .din  (din[c]),
            .q_o  (q[c*BITS +: BITS])
        );
    end
endmodule

// File: tb/dual_addr_latch_test.sv
module dual_addr_latch_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = '0;
    logic       en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [1:0] din = '0;
    logic [7:0] q;

    int checks = 0;
    int fails  = 0;
    int model_a [4];
    int model_b [4];

    dual_addr_latch uut (
        .clk (clk), .rst (rst), .addr (addr), .en_n (en_n),
        .clr_n (clr_n), .din (din), .q (q)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] model_word();
        logic [7:0] w = '0;
        for (int i = 0; i < 4; i++) begin
            w[i]     = model_a[i][0];
            w[4 + i] = model_b[i][0];
        end
        return w;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: q=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Behavioural model of one edge with the given controls.
    task automatic model_edge(input logic e, input logic c, input int a, input logic da, input logic db);
        if (e && !c) begin
            model_a = '{0, 0, 0, 0};
            model_b = '{0, 0, 0, 0};
        end else if (!e && !c) begin
            for (int i = 0; i < 4; i++) begin
                model_a[i] = (i == a) ? int'(da) : 0;
                model_b[i] = (i == a) ? int'(db) : 0;
            end
        end else if (!e && c) begin
            model_a[a] = int'(da);
            model_b[a] = int'(db);
        end
    endtask

    // Drive on falling edge, check R7 before the edge, check result after.
    task automatic step(input string tag, input logic e, input logic c, input int a,
                        input logic da, input logic db);
        en_n = e; clr_n = c; addr = 2'(a); din = {db, da};
        #1;
        check("R7 no change between edges", q, model_word());
        @(posedge clk);
        model_edge(e, c, a, da, db);
        @(negedge clk);
        check(tag, q, model_word());
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        model_a = '{0, 0, 0, 0};
        model_b = '{0, 0, 0, 0};
        check("R1 reset", q, 8'h00);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R4 R6: serial load A=1011 (bit3..0), B=0110 through addressable writes
        step("R4 R6 load", 1'b0, 1'b1, 0, 1'b1, 1'b0);
        step("R4 R6 load", 1'b0, 1'b1, 1, 1'b1, 1'b1);
        step("R4 R6 load", 1'b0, 1'b1, 2, 1'b0, 1'b1);
        step("R4 R6 load", 1'b0, 1'b1, 3, 1'b1, 1'b0);
        check("R6 lane mapping", q, 8'b0110_1011);
        // R5: memory mode, address and data wander
        for (int i = 0; i < 8; i++)
            step("R5 hold", 1'b1, 1'b1, i % 4, 1'(i), 1'(i >> 1));
        check("R5 pattern retained", q, 8'b0110_1011);
        // R4: random single-bit rewrites
        step("R4 rewrite", 1'b0, 1'b1, 2, 1'b1, 1'b0);
        step("R4 rewrite", 1'b0, 1'b1, 0, 1'b0, 1'b1);
        // R3: demultiplex walk, unaddressed outputs forced low
        for (int i = 0; i < 8; i++)
            step("R3 demux", 1'b0, 1'b0, i % 4, 1'(i >> 2 ^ 1), 1'(i));
        step("R3 demux addr3", 1'b0, 1'b0, 3, 1'b1, 1'b1);
        check("R3 demux pattern", q, 8'b1000_1000);
        // R8: memory mode keeps demux result
        step("R8 hold after demux", 1'b1, 1'b1, 0, 1'b0, 1'b0);
        step("R8 hold after demux", 1'b1, 1'b1, 1, 1'b1, 1'b1);
        check("R8 retained", q, 8'b1000_1000);
        // R2: reload then clear
        for (int i = 0; i < 4; i++)
            step("R4 reload", 1'b0, 1'b1, i, 1'b1, 1'b1);
        step("R2 clear", 1'b1, 1'b0, 2, 1'b1, 1'b1);
        check("R2 all low", q, 8'h00);
        step("R5 hold after clear", 1'b1, 1'b1, 1, 1'b1, 1'b1);
        // R1: reset in the middle of operation
        step("R4 before reset", 1'b0, 1'b1, 1, 1'b1, 1'b1);
        do_reset();
        step("R5 hold after reset", 1'b1, 1'b1, 3, 1'b1, 1'b1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule